// File: doc/BRIEF.md
# Alarm Match and Interrupt Status

This block sits beside a running calendar counter that holds time as packed BCD fields. It keeps six alarm bytes: seconds, minutes, hours, day, month and year. Each time the counter advances its seconds it pulses `sec_tick`, and the block then compares the alarm bytes with the current time. The alarm fires only when all six fields are equal, because no field can be marked "don't care". A hit sets a sticky alarm status bit. Software clears that bit by writing a 1 to it.

Three outputs are derived from the status bits:
- a level alarm interrupt, gated by an alarm interrupt enable;
- a one-cycle timer interrupt for every seconds tick, gated by a timer interrupt enable;
- a level wake request, gated by a separate wake enable.

A power-up flag sits in the same status byte. It is set by reset and cleared only by writing a 1 to it.

The alarm status is held by a two-state machine:
- ST_IDLE means no alarm is pending.
- The MATCH transition moves ST_IDLE to ST_PEND on a seconds tick with a full match.
- The ACK transition moves ST_PEND back to ST_IDLE on a write-one-to-clear, provided no new match arrives in the same cycle.
- Every other cycle holds the current state.

Registers are written through a small indexed write port.

Top module: `alm_match_irq`

## Requirements
- R1: After reset the outputs are `alm_sts`=0, `pwr_sts`=1, `irq_alarm`=0, `irq_timer`=0 and `wake_out`=0. All six alarm bytes and all enables reset to 0.
- R2: When `sec_tick` is high and all six fields of `tm_now` equal the alarm bytes, `alm_sts` reads 1 from the next cycle on. In `tm_now`, seconds occupy bits [7:0], then minutes, hours, day and month follow, with year in bits [47:40].
- R3: If any single field differs, a seconds tick does not set `alm_sts`. No field is a wildcard.
- R4: An equal time without `sec_tick` does not set `alm_sts`.
- R5: A write to index 8 with `wr_data[6]`=1 clears `alm_sts` on the next cycle. With `wr_data[6]`=0 the write leaves it unchanged.
- R6: A write to index 8 with `wr_data[7]`=1 clears `pwr_sts`. The flag is never set again except by reset.
- R7: When a clear of `alm_sts` coincides with a new match, the set wins and `alm_sts` stays 1.
- R8: `irq_alarm` equals `alm_sts` gated by bit 3 of the interrupt enable register (index 6).
- R9: `irq_timer` is high for the one cycle after a `sec_tick` if bit 2 of the interrupt enable register was set.
- R10: `wake_out` equals `alm_sts` gated by bit 1 of the wake enable register (index 7).
- R11: Writing 0 to the interrupt enable register drops `irq_alarm` on the next cycle and suppresses later timer pulses.
- R12: Write indices 0 to 5 load the alarm bytes for seconds, minutes, hours, day, month and year, in that order. Index 6 is the interrupt enable and index 7 is the wake enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse when the seconds field updates |
| tm_now | input | 48 | Current time, six packed BCD bytes |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 8 | Write data |
| alm_sts | output | 1 | Sticky alarm status |
| pwr_sts | output | 1 | Power-up flag |
| irq_alarm | output | 1 | Alarm interrupt (level) |
| irq_timer | output | 1 | Seconds timer interrupt (pulse) |
| wake_out | output | 1 | Wake request from the alarm |

## Verification
The assertions assume that `tm_now` is already stable and updated in the cycle that `sec_tick` is high. They also assume that a rise of `irq_alarm` or `wake_out` is caused either by a new alarm or by a write to the matching enable register.

The stimulus respects these assumptions:
- Inputs change only at the falling edge.
- A tick always carries the time value to be compared with it.
- Random cycles mix near-miss times, differing in one random field, with exact matches against the programmed alarm.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int          IDX_W        = 4;
    localparam logic [3:0]  IDX_IE       = 4'd6;
    localparam logic [3:0]  IDX_WAKE     = 4'd7;
    localparam logic [3:0]  IDX_STS      = 4'd8;
    localparam int          STS_ALM_BIT  = 6;
    localparam int          STS_PWR_BIT  = 7;
    localparam int          IE_ALM_BIT   = 3;
    localparam int          IE_TMR_BIT   = 2;
    localparam int          WAKE_ALM_BIT = 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } alm_state_e;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [FW-1:0]          wr_data,
    output logic [FIELDS*FW-1:0]   alarm_vec,
    output logic                   ie_alm,
    output logic                   ie_tmr,
    output logic                   wake_alm
);
    // one alarm byte per field, indexed by field number
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        logic [FW-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(f)) begin
                byte_q <= wr_data;
            end
        end
        assign alarm_vec[f*FW +: FW] = byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_alm   <= 1'b0;
            ie_tmr   <= 1'b0;
            wake_alm <= 1'b0;
        end else if (wr_en) begin
            if (wr_idx == IDX_IE) begin
                ie_alm <= wr_data[IE_ALM_BIT];
                ie_tmr <= wr_data[IE_TMR_BIT];
            end
            if (wr_idx == IDX_WAKE) begin
                wake_alm <= wr_data[WAKE_ALM_BIT];
            end
        end
    end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int FIELDS = 6,
    parameter int FW     = 8
) (
    input  logic [FIELDS*FW-1:0] tm_now,
    input  logic [FIELDS*FW-1:0] alarm_vec,
    output logic                 all_eq
);
    logic [FIELDS-1:0] fld_eq;

    // every field must match: there is no wildcard encoding
    for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
        assign fld_eq[f] = (tm_now[f*FW +: FW] == alarm_vec[f*FW +: FW]);
    end

    assign all_eq = &fld_eq;
endmodule

// File: rtl/alm_status_fsm.sv
module alm_status_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_alm,
    input  logic clr_pwr,
    output logic alm_sts,
    output logic pwr_sts
);
    alm_state_e st_q, st_d;
    logic       pwr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: MATCH sets, ACK clears; a new match beats a clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (hit)               st_d = ST_PEND;
            ST_PEND: if (clr_alm && !hit)   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        alm_sts = (st_q == ST_PEND);
        pwr_sts = pwr_q;
    end

    // power-up flag: set only by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
        end else if (clr_pwr) begin
            pwr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/alm_match_irq.sv
module alm_match_irq
    import alm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_tick,
    input  logic [FIELDS*FW-1:0]  tm_now,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [FW-1:0]         wr_data,
    output logic                  alm_sts,
    output logic                  pwr_sts,
    output logic                  irq_alarm,
    output logic                  irq_timer,
    output logic                  wake_out
);
    logic [FIELDS*FW-1:0] alarm_vec;
    logic ie_alm, ie_tmr, wake_alm;
    logic all_eq, hit, sts_wr, clr_alm, clr_pwr;
    logic tmr_q;

    alm_regs #(.FIELDS(FIELDS), .FW(FW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .alarm_vec (alarm_vec),
        .ie_alm    (ie_alm),
        .ie_tmr    (ie_tmr),
        .wake_alm  (wake_alm)
    );

    alm_field_cmp #(.FIELDS(FIELDS), .FW(FW)) cmp_i (
        .tm_now    (tm_now),
        .alarm_vec (alarm_vec),
        .all_eq    (all_eq)
    );

    assign hit     = sec_tick && all_eq;
    assign sts_wr  = wr_en && (wr_idx == IDX_STS);
    assign clr_alm = sts_wr && wr_data[STS_ALM_BIT];
    assign clr_pwr = sts_wr && wr_data[STS_PWR_BIT];

    alm_status_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_alm (clr_alm),
        .clr_pwr (clr_pwr),
        .alm_sts (alm_sts),
        .pwr_sts (pwr_sts)
    );

    // timer interrupt: one cycle per seconds event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= 1'b0;
        end else begin
            tmr_q <= sec_tick && ie_tmr;
        end
    end

    assign irq_timer = tmr_q;
    assign irq_alarm = alm_sts && ie_alm;
    assign wake_out  = alm_sts && wake_alm;
endmodule

// File: rtl/alm_match_irq_chk.sv
module alm_match_irq_chk
    import alm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sec_tick,
    input logic [FIELDS*FW-1:0] tm_now,
    input logic [FIELDS*FW-1:0] alarm_vec,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [FW-1:0]        wr_data,
    input logic                 alm_sts,
    input logic                 pwr_sts,
    input logic                 irq_alarm,
    input logic                 irq_timer,
    input logic                 wake_out
);
    a_r2_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_sts) |-> $past(sec_tick && (tm_now == alarm_vec)));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (tm_now == alarm_vec)) |=> alm_sts);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_sts && !(wr_en && wr_idx == IDX_STS && wr_data[STS_ALM_BIT])) |=> alm_sts);

    a_r6_pwr_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pwr_sts));

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_alarm) |-> ($rose(alm_sts) || $past(wr_en && wr_idx == IDX_IE)));

    a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_out) |-> ($rose(alm_sts) || $past(wr_en && wr_idx == IDX_WAKE)));

    a_r9_timer_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timer |-> $past(sec_tick));

    a_r11_ie_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_IE && wr_data == '0) |=> !irq_alarm);
endmodule

bind alm_match_irq alm_match_irq_chk #(.FIELDS(FIELDS), .FW(FW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .tm_now    (tm_now),
    .alarm_vec (alarm_vec),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .alm_sts   (alm_sts),
    .pwr_sts   (pwr_sts),
    .irq_alarm (irq_alarm),
    .irq_timer (irq_timer),
    .wake_out  (wake_out)
);

// File: tb/alm_match_irq_tb_top.sv
`timescale 1ns/1ps
module alm_match_irq_tb_top;
    localparam int WD_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sec_tick;
    logic [47:0] tm_now;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [7:0]  wr_data;
    logic        alm_sts, pwr_sts, irq_alarm, irq_timer, wake_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] m_alm [6];
    logic m_ie_a, m_ie_t, m_wk, m_as, m_ps;

    always #2 clk = ~clk;

    alm_match_irq dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tm_now(tm_now),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .alm_sts(alm_sts), .pwr_sts(pwr_sts), .irq_alarm(irq_alarm),
        .irq_timer(irq_timer), .wake_out(wake_out)
    );

    function automatic logic [47:0] pack_alarm();
        return {m_alm[5], m_alm[4], m_alm[3], m_alm[2], m_alm[1], m_alm[0]};
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [47:0] rand_time();
        logic [47:0] t;
        for (int f = 0; f < 6; f++) t[f*8 +: 8] = to_bcd(int'($urandom_range(0, 59)));
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle after a falling edge, check at the next falling edge
    task automatic apply(input bit we, input logic [3:0] idx, input logic [7:0] d,
                         input bit tk, input logic [47:0] t, input string tag);
        logic hit, clr, e_as, e_ps, e_tm;
        wr_en = we; wr_idx = idx; wr_data = d; sec_tick = tk; tm_now = t;
        hit  = tk && (t == pack_alarm());
        clr  = we && idx == 4'd8 && d[6];
        e_as = hit | (m_as & ~clr);
        e_ps = m_ps & ~(we && idx == 4'd8 && d[7]);
        e_tm = tk & m_ie_t;
        if (we) begin
            if (idx < 4'd6) m_alm[idx] = d;
            else if (idx == 4'd6) begin m_ie_a = d[3]; m_ie_t = d[2]; end
            else if (idx == 4'd7) m_wk = d[1];
        end
        m_as = e_as; m_ps = e_ps;
        @(negedge clk);
        chk(alm_sts == e_as, tag, 8'(alm_sts), 8'(e_as));
        chk(pwr_sts == e_ps, "R6", 8'(pwr_sts), 8'(e_ps));
        chk(irq_alarm == (e_as & m_ie_a), "R8", 8'(irq_alarm), 8'(e_as & m_ie_a));
        chk(wake_out == (e_as & m_wk), "R10", 8'(wake_out), 8'(e_as & m_wk));
        chk(irq_timer == e_tm, "R9", 8'(irq_timer), 8'(e_tm));
        wr_en = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(WD_CYC * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [47:0] a;
        void'($urandom(32'h5eed_0a1a));
        for (int f = 0; f < 6; f++) m_alm[f] = '0;
        m_ie_a = 0; m_ie_t = 0; m_wk = 0; m_as = 0; m_ps = 1;
        rst_n = 0; sec_tick = 0; tm_now = '0; wr_en = 0; wr_idx = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk(alm_sts == 0, "R1", 8'(alm_sts), 8'h0);
        chk(pwr_sts == 1, "R1", 8'(pwr_sts), 8'h1);
        chk(irq_alarm == 0 && irq_timer == 0 && wake_out == 0, "R1",
            {5'd0, irq_alarm, irq_timer, wake_out}, 8'h0);

        // R12: enables and alarm bytes through their indices
        apply(1, 4'd6, 8'h0C, 0, '0, "R12");
        apply(1, 4'd7, 8'h02, 0, '0, "R12");
        a = {8'h24, 8'h06, 8'h21, 8'h08, 8'h15, 8'h30};
        for (int f = 0; f < 6; f++) apply(1, 4'(f), a[f*8 +: 8], 0, '0, "R12");

        // R3: each single-field difference blocks the alarm
        for (int f = 0; f < 6; f++) begin
            logic [47:0] t;
            t = a;
            t[f*8 +: 8] = t[f*8 +: 8] ^ 8'h01;
            apply(0, '0, '0, 1, t, "R3");
        end
        // R4: equal without a tick
        apply(0, '0, '0, 0, a, "R4");
        // R2: full match on a tick
        apply(0, '0, '0, 1, a, "R2");
        // R5: writing 0 keeps it, writing bit 6 clears it
        apply(1, 4'd8, 8'h00, 0, '0, "R5");
        apply(1, 4'd8, 8'h40, 0, '0, "R5");
        // R7: clear and new match in the same cycle
        apply(0, '0, '0, 1, a, "R2");
        apply(1, 4'd8, 8'h40, 1, a, "R7");
        // R11: zero interrupt enable drops both sources
        apply(1, 4'd6, 8'h00, 0, '0, "R11");
        chk(irq_alarm == 0, "R11", 8'(irq_alarm), 8'h0);
        apply(0, '0, '0, 1, a, "R11");
        chk(irq_timer == 0, "R11", 8'(irq_timer), 8'h0);
        // R6: power-up flag clears and stays cleared
        apply(1, 4'd8, 8'h80, 0, '0, "R6");
        apply(1, 4'd8, 8'h00, 0, '0, "R6");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [47:0] t;
            op = int'($urandom_range(0, 9));
            if (op < 3) begin
                apply(0, '0, '0, 1, pack_alarm(), "R2");
            end else if (op < 5) begin
                t = pack_alarm();
                t[$urandom_range(0, 5)*8 +: 8] = to_bcd(int'($urandom_range(60, 99)));
                apply(0, '0, '0, 1, t, "R3");
            end else if (op < 6) begin
                apply(0, '0, '0, $urandom_range(0, 1) == 1, rand_time(), "R2");
            end else if (op < 8) begin
                apply(1, 4'($urandom_range(0, 5)), to_bcd(int'($urandom_range(0, 3))), 0, '0, "R12");
            end else begin
                apply(1, 4'($urandom_range(6, 8)), 8'($urandom), $urandom_range(0, 1) == 1,
                      pack_alarm(), "R5");
            end
        end
        done = 1'b1;
        summary();
    end
endmodule